// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits between a byte-wide program memory with wait states and an instruction execution unit. It runs ahead of execution: while the execution unit works on one instruction, the block keeps reading later program bytes into a small circular queue. Because of this, the memory wait time overlaps with execution instead of adding to it. Each program byte read holds the memory address for a configurable number of wait clocks. The byte is captured on the last of those clocks, and the next read starts on the following clock for as long as the queue has space.

The execution unit asks for a whole instruction of one to three bytes. If the queue holds all of those bytes, the block grants the request and hands the bytes over together in a single clock. If it does not, the block stalls the execution unit. A redirect input with a target address throws away the queued bytes and any read in progress, and starts reading at the target. The wait-state configuration has a shared value and separate override values for program fetches and for data accesses. The block resolves the data-side wait count here so that a neighbouring data path can use it.

Top module: `insn_prefetch_queue`

## Requirements
- R1: While synchronous reset is asserted and in the first clock after it, the queue count is 0, `mem_rd` is 1 and `mem_addr` is 0.
- R2: A fetch keeps `mem_rd` high and `mem_addr` stable for W clocks. The byte on `mem_rdata` in the W-th clock is written into the queue at the end of that clock, so the count rises one clock later.
- R3: The fetch wait W is `cfg_fetch_wait` when `cfg_fetch_sep` is 1 and `cfg_wait_shared` otherwise. `data_wait_o` is `cfg_data_wait` when `cfg_data_sep` is 1 and `cfg_wait_shared` otherwise. A selected value of 0 is treated as 1.
- R4: When a fetch completes and the queue still has room, the next fetch starts in the next clock at the address plus one. No idle clock is inserted.
- R5: The queue never holds more than DEPTH bytes (default 4). The in-flight byte counts against the free space, and when no space remains `mem_rd` goes low and the address stops advancing.
- R6: When `ex_req` is 1, `ex_len` is 1, 2 or 3, and the queue count is at least `ex_len`, `ex_grant` is 1 in the same clock. `ex_insn[7:0]` then carries the oldest byte, `[15:8]` the next and `[23:16]` the third. Byte lanes beyond `ex_len` read 0, and exactly `ex_len` bytes leave the queue at the clock edge.
- R7: When `ex_req` is 1 and `ex_len` is nonzero but larger than the queue count, `ex_stall` is 1, `ex_grant` is 0 and nothing leaves the queue.
- R8: `redir_valid` has priority over everything else. In that clock there is no grant. In the next clock the count is 0, `mem_rd` is 1 and `mem_addr` equals the target, and bytes granted afterwards come from the target onward.
- R9: With W = 4 and a request for one 1-byte instruction every four clocks, once one byte is queued every request is granted without a stall.
- R10: A request with `ex_len` = 0 is ignored: no grant, no stall, and the queue count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wait_shared | input | 3 | Wait count shared by fetch and data accesses |
| cfg_fetch_sep | input | 1 | Use separate fetch wait count |
| cfg_fetch_wait | input | 3 | Separate fetch wait count |
| cfg_data_sep | input | 1 | Use separate data wait count |
| cfg_data_wait | input | 3 | Separate data wait count |
| data_wait_o | output | 3 | Resolved wait count for data accesses |
| mem_rd | output | 1 | Program memory read active |
| mem_addr | output | AW (16) | Program memory byte address |
| mem_rdata | input | 8 | Program memory read data |
| redir_valid | input | 1 | Redirect fetching |
| redir_addr | input | AW (16) | Redirect target address |
| ex_req | input | 1 | Execution unit requests an instruction |
| ex_len | input | 2 | Requested instruction length in bytes |
| ex_grant | output | 1 | Instruction bytes delivered this clock |
| ex_stall | output | 1 | Not enough bytes queued |
| ex_insn | output | 24 | Instruction bytes, oldest in the low lane |
| q_count | output | clog2(DEPTH+1) (3) | Bytes currently queued |

## Verification
The assertions assume that program memory returns a valid byte for the held address by the last wait clock. They also assume that `ex_req` and `ex_len` do not change within a clock, and that a redirect target is a plain address with no alignment rule. The bench models memory as a combinational function of `mem_addr`, so the assumed data timing always holds. It changes requests and redirects only just after a rising edge and samples at the falling edge. The byte-order and stall checks rely on requests staying asserted until they are granted, which is how the driver behaves.

// File: rtl/ipq_pkg.sv
package ipq_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned MAX_LEN = 3;
    localparam int unsigned INSN_W  = BYTE_W * MAX_LEN;
    localparam int unsigned WAIT_W  = 3;

    typedef logic [WAIT_W-1:0] wait_t;

    // Choose override or shared count; a zero count behaves as one clock.
    function automatic wait_t resolve_wait(input wait_t shared_v, input logic use_own,
                                           input wait_t own_v);
        wait_t sel;
        sel = use_own ? own_v : shared_v;
        return (sel == '0) ? wait_t'(1) : sel;
    endfunction
endpackage

// File: rtl/ipq_wait_sel.sv
module ipq_wait_sel
    import ipq_pkg::*;
(
    input  wait_t cfg_shared,
    input  logic  fetch_sep,
    input  wait_t fetch_own,
    input  logic  data_sep,
    input  wait_t data_own,
    output wait_t fetch_wait,
    output wait_t data_wait
);
    always_comb begin
        fetch_wait = resolve_wait(cfg_shared, fetch_sep, fetch_own);
        data_wait  = resolve_wait(cfg_shared, data_sep, data_own);
    end

    always_comb begin
        AST_WAIT_NONZERO: assert (fetch_wait != '0 && data_wait != '0); // R3
    end
endmodule

// File: rtl/ipq_fetch_ctrl.sv
module ipq_fetch_ctrl
    import ipq_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  wait_t         wait_n,
    input  logic          room,
    input  logic          redir_valid,
    input  logic [AW-1:0] redir_addr,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          done
);
    typedef struct packed {
        logic          busy;
        wait_t         cnt;
        logic [AW-1:0] addr;
    } fst_t;

    fst_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        done = st_q.busy && (st_q.cnt >= wait_n);
        if (redir_valid) begin
            st_d.busy = 1'b1;
            st_d.cnt  = wait_t'(1);
            st_d.addr = redir_addr;
        end else begin
            if (done) begin
                st_d.addr = st_q.addr + 1'b1;
            end
            if (!st_q.busy || done) begin
                st_d.busy = room;
                st_d.cnt  = wait_t'(1);
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy <= 1'b1;
            st_q.cnt  <= wait_t'(1);
            st_q.addr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_rd   = st_q.busy;
    assign mem_addr = st_q.addr;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (done && !redir_valid) |=> (st_q.addr == AW'($past(st_q.addr) + 1'b1))); // R4
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && !done && !redir_valid) |=> (st_q.busy && $stable(st_q.addr))); // R2
endmodule

// File: rtl/ipq_byte_queue.sv
module ipq_byte_queue
    import ipq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_byte,
    input  logic [1:0]        pop_len,
    output logic [CW-1:0]     count,
    output logic [INSN_W-1:0] peek
);
    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [PW-1:0]                head;
        logic [CW-1:0]                count;
    } qst_t;

    qst_t st_q, st_d;

    function automatic logic [PW-1:0] wrap(input int v);
        return PW'(v % int'(DEPTH));
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.head  = '0;
            st_d.count = '0;
        end else begin
            if (push) begin
                st_d.mem[wrap(int'(st_q.head) + int'(st_q.count))] = push_byte;
            end
            st_d.head  = wrap(int'(st_q.head) + int'(pop_len));
            st_d.count = CW'(int'(st_q.count) + int'(push) - int'(pop_len));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count = st_q.count;

    for (genvar i = 0; i < MAX_LEN; i++) begin : g_peek
        assign peek[i*BYTE_W +: BYTE_W] = st_q.mem[wrap(int'(st_q.head) + i)];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        st_q.count <= CW'(DEPTH)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        CW'(pop_len) <= st_q.count); // R6
endmodule

// File: rtl/insn_prefetch_queue.sv
module insn_prefetch_queue
    import ipq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAIT_W-1:0] cfg_wait_shared,
    input  logic              cfg_fetch_sep,
    input  logic [WAIT_W-1:0] cfg_fetch_wait,
    input  logic              cfg_data_sep,
    input  logic [WAIT_W-1:0] cfg_data_wait,
    output logic [WAIT_W-1:0] data_wait_o,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              redir_valid,
    input  logic [AW-1:0]     redir_addr,
    input  logic              ex_req,
    input  logic [1:0]        ex_len,
    output logic              ex_grant,
    output logic              ex_stall,
    output logic [INSN_W-1:0] ex_insn,
    output logic [CW-1:0]     q_count
);
    wait_t             fetch_wait;
    logic              fetch_done;
    logic              room;
    logic              len_ok;
    logic              enough;
    logic [1:0]        pop_len;
    logic [INSN_W-1:0] peek;
    int                count_nx;

    ipq_wait_sel u_wait (
        .cfg_shared (cfg_wait_shared),
        .fetch_sep  (cfg_fetch_sep),
        .fetch_own  (cfg_fetch_wait),
        .data_sep   (cfg_data_sep),
        .data_own   (cfg_data_wait),
        .fetch_wait (fetch_wait),
        .data_wait  (data_wait_o)
    );

    ipq_fetch_ctrl #(.AW(AW)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .wait_n      (fetch_wait),
        .room        (room),
        .redir_valid (redir_valid),
        .redir_addr  (redir_addr),
        .mem_rd      (mem_rd),
        .mem_addr    (mem_addr),
        .done        (fetch_done)
    );

    ipq_byte_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (redir_valid),
        .push      (fetch_done && !redir_valid),
        .push_byte (mem_rdata),
        .pop_len   (pop_len),
        .count     (q_count),
        .peek      (peek)
    );

    always_comb begin
        len_ok   = (ex_len != 2'd0);
        enough   = (int'(q_count) >= int'(ex_len));
        ex_grant = ex_req && len_ok && !redir_valid && enough;
        ex_stall = ex_req && len_ok && !redir_valid && !enough;
        pop_len  = ex_grant ? ex_len : 2'd0;
        count_nx = int'(q_count) + int'(fetch_done) - int'(pop_len);
        room     = (count_nx < int'(DEPTH));
    end

    for (genvar i = 0; i < MAX_LEN; i++) begin : g_lane
        assign ex_insn[i*BYTE_W +: BYTE_W] =
            (ex_grant && (i < int'(ex_len))) ? peek[i*BYTE_W +: BYTE_W] : '0;
    end

    AST_REDIR_RESTART: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (mem_rd && (mem_addr == $past(redir_addr)) && (q_count == '0))); // R8
    AST_GRANT_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ex_grant, ex_stall})); // R7
    AST_STALL_SHORT: assert property (@(posedge clk) disable iff (rst)
        ex_stall |-> (int'(q_count) < int'(ex_len))); // R7
    AST_LEN0_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ex_req && ex_len == 2'd0) |-> (!ex_grant && !ex_stall)); // R10
    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
        (q_count == CW'(DEPTH) && !ex_grant && !redir_valid) |=> !mem_rd); // R5
endmodule

// File: tb/insn_prefetch_queue_tb_top.sv
module insn_prefetch_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cfg_wait_shared, cfg_fetch_wait, cfg_data_wait;
    logic        cfg_fetch_sep, cfg_data_sep;
    logic [2:0]  data_wait_o;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        redir_valid;
    logic [15:0] redir_addr;
    logic        ex_req;
    logic [1:0]  ex_len;
    logic        ex_grant, ex_stall;
    logic [23:0] ex_insn;
    logic [2:0]  q_count;

    always #5 clk = ~clk;

    insn_prefetch_queue dut_i (
        .clk(clk), .rst(rst),
        .cfg_wait_shared(cfg_wait_shared), .cfg_fetch_sep(cfg_fetch_sep),
        .cfg_fetch_wait(cfg_fetch_wait), .cfg_data_sep(cfg_data_sep),
        .cfg_data_wait(cfg_data_wait), .data_wait_o(data_wait_o),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .ex_req(ex_req), .ex_len(ex_len), .ex_grant(ex_grant),
        .ex_stall(ex_stall), .ex_insn(ex_insn), .q_count(q_count)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        logic [15:0] t;
        t = a * 16'd37 + 16'd11;
        return t[7:0] ^ a[15:8];
    endfunction

    assign mem_rdata = mem_byte(mem_addr);

    int          n_checks = 0;
    int          n_fails  = 0;
    int          stall_seen;
    logic [15:0] pc;
    logic [23:0] exp_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    // Monitor: each grant pops the oldest expected instruction word.
    always @(negedge clk) begin
        if (!rst && ex_grant) begin
            if (exp_q.size() == 0) begin
                chk("R6 grant with nothing expected", 32'(ex_grant), 32'd0);
            end else begin
                chk("R6 instruction bytes", 32'(ex_insn), 32'(exp_q.pop_front()));
            end
        end
    end

    // Driver: predicts the word, then requests until granted.
    task automatic take(input int len);
        logic [23:0] w;
        w = '0;
        for (int i = 0; i < len; i++) w[i*8 +: 8] = mem_byte(pc + 16'(i));
        exp_q.push_back(w);
        pc = pc + 16'(len);
        stall_seen = 0;
        @(posedge clk); #1;
        ex_req = 1'b1;
        ex_len = 2'(len);
        forever begin
            @(negedge clk);
            if (ex_grant) break;
            if (ex_stall) begin
                stall_seen++;
                chk("R7 stall only when short", 32'(int'(q_count) < len), 32'd1);
            end
        end
        @(posedge clk); #1;
        ex_req = 1'b0;
    endtask

    task automatic redirect(input logic [15:0] target);
        @(posedge clk); #1;
        redir_valid = 1'b1;
        redir_addr  = target;
        @(negedge clk);
        chk("R8 no grant during redirect", 32'(ex_grant), 32'd0);
        @(posedge clk); #1;
        redir_valid = 1'b0;
        pc = target;
        @(negedge clk);
        chk("R8 queue flushed", 32'(q_count), 32'd0);
        chk("R8 fetch at target", 32'(mem_addr), 32'(target));
        chk("R8 fetch active", 32'(mem_rd), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        cfg_wait_shared = 3'd4; cfg_fetch_sep = 1'b0; cfg_fetch_wait = 3'd0;
        cfg_data_sep = 1'b0; cfg_data_wait = 3'd0;
        redir_valid = 1'b0; redir_addr = '0; ex_req = 1'b0; ex_len = 2'd0;
        pc = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk("R1 count", 32'(q_count), 32'd0);
        chk("R1 mem_rd", 32'(mem_rd), 32'd1);
        chk("R1 mem_addr", 32'(mem_addr), 32'd0);

        // R2 four wait clocks per byte
        repeat (3) @(negedge clk);
        chk("R2 address held", 32'(mem_addr), 32'd0);
        chk("R2 not yet queued", 32'(q_count), 32'd0);
        @(negedge clk);
        chk("R2 R4 next address", 32'(mem_addr), 32'd1);
        chk("R2 byte queued", 32'(q_count), 32'd1);

        // R5 fill and pause
        repeat (30) @(negedge clk);
        chk("R5 count full", 32'(q_count), 32'd4);
        chk("R5 fetch paused", 32'(mem_rd), 32'd0);
        chk("R5 address stopped", 32'(mem_addr), 32'd4);

        // R10 zero length ignored
        @(posedge clk); #1;
        ex_req = 1'b1; ex_len = 2'd0;
        @(negedge clk);
        chk("R10 no grant", 32'(ex_grant), 32'd0);
        chk("R10 no stall", 32'(ex_stall), 32'd0);
        @(posedge clk); #1;
        ex_req = 1'b0;
        @(negedge clk);
        chk("R10 count unchanged", 32'(q_count), 32'd4);

        // R6 / R7 mixed lengths
        take(3);
        take(1);
        take(2);
        take(3);
        chk("R7 stall observed for 3-byte request", 32'(stall_seen > 0), 32'd1);
        take(1);
        take(2);

        // R8 redirects, full queue then mid-fetch
        repeat (20) @(negedge clk);
        redirect(16'h1234);
        take(2);
        take(1);
        take(3);
        redirect(16'h00FE);
        take(3);
        take(2);

        // R3 wait selection
        cfg_fetch_sep = 1'b1; cfg_fetch_wait = 3'd2;
        #1 chk("R3 data uses shared", 32'(data_wait_o), 32'd4);
        redirect(16'h0200);
        @(negedge clk);
        chk("R3 fetch wait 2 hold", 32'(mem_addr), 32'h200);
        @(negedge clk);
        chk("R3 fetch wait 2 step", 32'(mem_addr), 32'h201);
        cfg_fetch_wait = 3'd0;
        redirect(16'h0300);
        @(negedge clk);
        chk("R3 zero wait acts as one", 32'(mem_addr), 32'h301);
        take(3);
        cfg_data_sep = 1'b1; cfg_data_wait = 3'd6;
        #1 chk("R3 data override", 32'(data_wait_o), 32'd6);
        cfg_data_wait = 3'd0;
        #1 chk("R3 data zero acts as one", 32'(data_wait_o), 32'd1);
        cfg_data_sep = 1'b0; cfg_wait_shared = 3'd5;
        #1 chk("R3 data follows shared", 32'(data_wait_o), 32'd5);

        // R9 one-byte stream at W=4, no stalls
        cfg_fetch_sep = 1'b0; cfg_wait_shared = 3'd4;
        redirect(16'h0400);
        while (q_count < 3'd1) @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            @(posedge clk); #1;
            exp_q.push_back({16'h0, mem_byte(pc)});
            pc = pc + 16'd1;
            ex_req = 1'b1; ex_len = 2'd1;
            @(negedge clk);
            chk("R9 granted without stall", 32'({ex_grant, ex_stall}), 32'b10);
            @(posedge clk); #1;
            ex_req = 1'b0;
            repeat (2) @(posedge clk);
        end

        @(negedge clk);
        chk("R6 all expected words consumed", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule